// File: doc/BRIEF.md
# Key-byte candidate elimination engine

The engine recovers one secret key byte from a stream of leaked observations. Each observation pairs a known plaintext byte with one bit: the most significant bit of the forward AES substitution applied to (plaintext XOR key). The engine tracks all 256 possible key bytes in a survivor mask, one bit per hypothesis. For each observation it walks every hypothesis in turn and computes the predicted substitution output. A hypothesis whose predicted top bit disagrees with the observed bit is removed for good.

Observations arrive on a valid/ready stream. The walk takes one hypothesis per clock, so the engine holds ready low for 256 cycles after each accepted observation. The source must keep valid, plaintext and bit steady until the beat is accepted. A start pulse, which is honoured only while idle, restores the full candidate set. The engine reports how many hypotheses survive. Once exactly one remains, it flags completion and presents that key. An empty set raises an error flag, which means the observations were inconsistent.

Top module: `keyelim_engine`

## Requirements
- R1: After reset, or a start pulse while idle, all 256 hypotheses are alive: survivors = 256, done = 0, error = 0, obs_ready = 1.
- R2: An observation is accepted on a clock edge where obs_valid and obs_ready are both 1. obs_ready then reads 0 for exactly 256 consecutive cycles, and obs_valid is ignored during that time.
- R3: When a walk ends, hypothesis k (0x00..0xFF) is alive only if it was alive before the walk and bit 7 of S(pt XOR k) equals the observed bit. survivors equals the number of live hypotheses.
- R4: An eliminated hypothesis comes back only through reset or start, so survivors never rises otherwise.
- R5: done is 1 exactly when the engine is idle and survivors = 1. key_out then holds the single live hypothesis.
- R6: error is 1 exactly when survivors = 0.
- R7: A start pulse while a walk is in progress has no effect.
- R8: S is the standard AES forward substitution, for example S(0x00) = 0x63 and S(0x53) = 0xED.
- R9: While the engine is idle and start is low, the survivor set does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Restore all hypotheses (honoured when idle) |
| obs_valid | input | 1 | Observation beat valid |
| obs_ready | output | 1 | Engine can accept an observation |
| obs_pt | input | 8 | Known plaintext byte |
| obs_msb | input | 1 | Observed top bit of the substitution output |
| survivors | output | 9 | Number of live hypotheses (0..256) |
| done | output | 1 | Idle with exactly one survivor |
| error | output | 1 | No hypothesis survives |
| key_out | output | 8 | Surviving key when done |

## Verification
The assertions assume that start is asserted only for single cycles. They also assume that the source keeps obs_valid and its data steady until the beat is taken. The bench drives every beat and start pulse on the falling edge under those rules and waits for obs_ready before it presents the next observation. The live count is checked against the popcount of the survivor mask. The count may never rise except through start. A walk always lasts exactly 256 busy cycles. The survivor set may not change while the engine is idle.

// File: rtl/keyelim_pkg.sv
package keyelim_pkg;
  localparam int KEY_W   = 8;
  localparam int NUM_HYP = 1 << KEY_W;
  localparam int CNT_W   = KEY_W + 1;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] x;
    acc = 8'h00;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
    end
    return acc;
  endfunction

  // inverse as x^254 (0 maps to 0), followed by the affine map
  function automatic logic [7:0] fwd_sbox(input logic [7:0] v);
    logic [7:0] sq;
    logic [7:0] inv;
    logic [7:0] r;
    sq  = v;
    inv = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq  = gf_mul(sq, sq);
      inv = gf_mul(inv, sq);
    end
    r = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
            ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    return r;
  endfunction
endpackage

// File: rtl/keyelim_sbox.sv
module keyelim_sbox
  import keyelim_pkg::*;
(
  input  logic [KEY_W-1:0] din,
  output logic [KEY_W-1:0] dout
);
  always_comb dout = fwd_sbox(din);
endmodule

// File: rtl/keyelim_survivors.sv
module keyelim_survivors
  import keyelim_pkg::*;
#(
  parameter int N = NUM_HYP,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill,
  input  logic          kill,
  input  logic [IW-1:0] idx,
  output logic [N-1:0]  alive
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               alive[g] <= 1'b1;
      else if (fill)                            alive[g] <= 1'b1;
      else if (kill && (idx == IW'(g)))         alive[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/keyelim_tally.sv
module keyelim_tally
  import keyelim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill,
  input  logic             kill,
  input  logic             keep,
  input  logic [KEY_W-1:0] idx,
  output logic [CNT_W-1:0] count,
  output logic [KEY_W-1:0] last_keep
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count     <= CNT_W'(NUM_HYP);
      last_keep <= '0;
    end else if (fill) begin
      count     <= CNT_W'(NUM_HYP);
      last_keep <= '0;
    end else if (kill) begin
      count     <= count - 1'b1;
    end else if (keep) begin
      last_keep <= idx;
    end
  end
endmodule

// File: rtl/keyelim_engine.sv
module keyelim_engine
  import keyelim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             obs_valid,
  output logic             obs_ready,
  input  logic [KEY_W-1:0] obs_pt,
  input  logic             obs_msb,
  output logic [CNT_W-1:0] survivors,
  output logic             done,
  output logic             error,
  output logic [KEY_W-1:0] key_out
);
  logic               busy;
  logic [KEY_W-1:0]   hyp;
  logic [KEY_W-1:0]   pt_q;
  logic               msb_q;
  logic [NUM_HYP-1:0] alive_mask;
  logic [KEY_W-1:0]   pred;
  logic               accept, fill, cur_alive, match, kill, keep;

  assign obs_ready = !busy;
  assign accept    = obs_valid && obs_ready;
  assign fill      = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      hyp   <= '0;
      pt_q  <= '0;
      msb_q <= 1'b0;
    end else if (accept) begin
      busy  <= 1'b1;
      hyp   <= '0;
      pt_q  <= obs_pt;
      msb_q <= obs_msb;
    end else if (busy) begin
      hyp <= hyp + 1'b1;
      if (hyp == KEY_W'(NUM_HYP - 1)) busy <= 1'b0;
    end
  end

  keyelim_sbox u_sbox (.din(pt_q ^ hyp), .dout(pred));

  assign cur_alive = alive_mask[hyp];
  assign match     = (pred[KEY_W-1] == msb_q);
  assign kill      = busy && cur_alive && !match;
  assign keep      = busy && cur_alive && match;

  keyelim_survivors #(.N(NUM_HYP)) u_surv (
    .clk(clk), .rst_n(rst_n), .fill(fill), .kill(kill), .idx(hyp), .alive(alive_mask)
  );

  keyelim_tally u_tally (
    .clk(clk), .rst_n(rst_n), .fill(fill), .kill(kill), .keep(keep), .idx(hyp),
    .count(survivors), .last_keep(key_out)
  );

  assign done  = !busy && (survivors == CNT_W'(1));
  assign error = (survivors == '0);
endmodule

// File: rtl/keyelim_engine_chk.sv
module keyelim_engine_chk
  import keyelim_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               obs_valid,
  input logic               obs_ready,
  input logic [CNT_W-1:0]   survivors,
  input logic               done,
  input logic               error,
  input logic [NUM_HYP-1:0] mask
);
  logic [CNT_W-1:0] busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     busy_cnt <= '0;
    else if (obs_valid && obs_ready) busy_cnt <= '0;
    else if (!obs_ready)            busy_cnt <= busy_cnt + 1'b1;
  end

  AST_COUNT_MATCHES_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    survivors == CNT_W'($countones(mask))); // R3
  AST_NO_REVIVAL: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> survivors <= $past(survivors)); // R4
  AST_WALK_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(obs_ready) |-> busy_cnt == CNT_W'(NUM_HYP)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones(mask) == 1); // R5
  AST_ERROR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> mask == '0); // R6
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (obs_ready && !start) |=> $stable(mask)); // R9
endmodule

bind keyelim_engine keyelim_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .obs_valid(obs_valid), .obs_ready(obs_ready),
  .survivors(survivors), .done(done), .error(error), .mask(alive_mask)
);

// File: tb/keyelim_engine_tb.sv
module keyelim_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       obs_valid = 1'b0;
  logic       obs_ready;
  logic [7:0] obs_pt = '0;
  logic       obs_msb = 1'b0;
  logic [8:0] survivors;
  logic       done, error;
  logic [7:0] key_out;

  int checks = 0;
  int fails  = 0;
  logic [7:0] sb [256];
  bit         live [256];
  int         live_n;
  bit         finished = 0;

  always #5 clk = ~clk;

  keyelim_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .obs_valid(obs_valid), .obs_ready(obs_ready),
    .obs_pt(obs_pt), .obs_msb(obs_msb), .survivors(survivors), .done(done),
    .error(error), .key_out(key_out)
  );

  function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
    int r = 0;
    int x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ x;
      x = x << 1;
      if (x > 255) x = x ^ 9'h11B;
    end
    return 8'(r);
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
    return 8'((v << n) | (v >> (8 - n)));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic model_fill();
    for (int k = 0; k < 256; k++) live[k] = 1;
    live_n = 256;
  endtask

  task automatic model_obs(input logic [7:0] p, input logic b);
    for (int k = 0; k < 256; k++)
      if (live[k] && (sb[p ^ 8'(k)][7] != b)) begin
        live[k] = 0;
        live_n--;
      end
  endtask

  function automatic int model_key();
    int r = 0;
    for (int k = 0; k < 256; k++) if (live[k]) r = k;
    return r;
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // present one beat, optionally pulse start mid-walk; returns busy length
  task automatic send(input logic [7:0] p, input logic b, input bit mid_start, output int busy_len);
    @(negedge clk);
    obs_valid = 1'b1; obs_pt = p; obs_msb = b;
    while (!obs_ready) @(negedge clk);
    @(negedge clk);
    obs_valid = 1'b0; obs_pt = ~p; obs_msb = ~b;
    busy_len = 0;
    while (!obs_ready) begin
      busy_len++;
      if (mid_start && busy_len == 10) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic check_state(input string tag);
    check({tag, " survivors"}, survivors, live_n);
    check({tag, " done"}, done, live_n == 1);
    check({tag, " error"}, error, live_n == 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin
    int blen;
    logic [7:0] p;
    logic [7:0] key;
    // bench substitution: brute-force inverse plus affine map
    for (int a = 0; a < 256; a++) begin
      logic [7:0] inv = 8'h00;
      for (int c = 1; c < 256; c++) if (mul(8'(a), 8'(c)) == 8'h01) inv = 8'(c);
      sb[a] = inv ^ rotl(inv, 1) ^ rotl(inv, 2) ^ rotl(inv, 3) ^ rotl(inv, 4) ^ 8'h63;
    end
    check("R8 S(0x00)", sb[8'h00], 8'h63);
    check("R8 S(0x53)", sb[8'h53], 8'hED);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    model_fill();
    check("R1 reset survivors", survivors, 256);
    check("R1 reset done", done, 0);
    check("R1 reset error", error, 0);
    check("R1 reset ready", obs_ready, 1);

    // R3 R5 R8: recover a spread of keys from consistent observations
    for (int t = 0; t < 16; t++) begin
      key = 8'(t * 17 + 3);
      pulse_start();
      model_fill();
      check("R1 start survivors", survivors, 256);
      for (int s = 0; s < 40 && live_n > 1; s++) begin
        p = 8'(s * 73 + t * 29 + 11);
        send(p, sb[p ^ key][7], 0, blen);
        model_obs(p, sb[p ^ key][7]);
        check("R2 walk length", blen, 256);
        check_state("R3");
      end
      check("R5 done", done, 1);
      check("R5 R8 key_out", key_out, key);
      check("R5 model key", model_key(), key);
    end

    // R7: start during a walk is ignored
    pulse_start();
    model_fill();
    send(8'h25, 1'b1, 1, blen);
    model_obs(8'h25, 1'b1);
    check("R7 start while busy survivors", survivors, live_n);
    check("R7 walk length", blen, 256);

    // R9: idle without start keeps the set (valid low, several cycles)
    repeat (20) @(negedge clk);
    check("R9 idle survivors", survivors, live_n);

    // R6 R4: contradictory observations empty the set, and it stays empty
    pulse_start();
    model_fill();
    send(8'h10, 1'b0, 0, blen);
    model_obs(8'h10, 1'b0);
    check_state("R3 half");
    send(8'h10, 1'b1, 0, blen);
    model_obs(8'h10, 1'b1);
    check("R6 error raised", error, 1);
    check("R6 survivors zero", survivors, 0);
    send(8'h77, 1'b0, 0, blen);
    check("R4 no revival", survivors, 0);
    check("R6 error held", error, 1);
    check("R5 not done when empty", done, 0);

    pulse_start();
    check("R1 start after error", survivors, 256);
    check("R1 error cleared", error, 0);

    finished = 1;
    summary();
  end
endmodule